// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the low address bits for a short memory burst. A burst starts when either of two active-low address strobes is seen at a rising clock edge. The block then captures an external start value and presents it as the first burst address. After that, each clock where the active-low advance input is asserted moves the burst to its next address, and each clock where advance is released holds the current address (suspend). The upper address bits, the storage array and the data path sit outside this block and stay fixed for the whole burst.

Two address orders are available. With the order-select input low, the burst counts upward from the start value and wraps at the burst length. With it high, each beat's address is the start value XORed with the beat number. At board level the order-select input is meant to be pulled high, so an undriven pin gives interleaved order. A separate beat index counts beats from zero whatever the order, so the data path can tell which beat is active. The burst length is 2**BEAT_BITS beats. The default of 2 bits gives four beats.

Top module: `burst_seq_gen`

## Requirements
- R1: When `strb_proc_n` is low at a rising edge, `addr_lsb` equals `start_addr` and `beat_idx` equals 0 after that edge.
- R2: When `strb_ctl_n` is low at a rising edge, the same load happens, whatever the state of `strb_proc_n`.
- R3: A load takes priority over `adv_n`. A strobe and a low `adv_n` at the same edge still give the start value and beat 0.
- R4: With `order_sel` = 0 (linear), beat k carries (start + k) mod 2**BEAT_BITS. From start 1 the four addresses are 1, 2, 3, 0.
- R5: With `order_sel` = 1 (interleaved), beat k carries start XOR k. From start 01 the order is 01, 00, 11, 10. From start 10 it is 10, 11, 00, 01.
- R6: When both strobes are high and `adv_n` is low at an edge, `beat_idx` increments by one and `addr_lsb` moves to the next address in the selected order.
- R7: When both strobes are high and `adv_n` is high, `addr_lsb` and `beat_idx` keep their values (suspend). A later advance resumes from the held beat.
- R8: After the last beat, further advances wrap. `beat_idx` returns to 0 and `addr_lsb` returns to the start value, then the sequence repeats.
- R9: A high `rst` at a rising edge clears `addr_lsb` and `beat_idx` to 0, and overrides any strobe.
- R10: `beat_idx` runs 0, 1, 2, 3 in both orders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | BEAT_BITS | External start value of the burst |
| strb_proc_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Advance request, active low; high suspends |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_lsb | output | BEAT_BITS | Registered current low address bits |
| beat_idx | output | BEAT_BITS | Registered beat number within the burst |

## Verification
The hardest case to reach is a burst that is suspended in the middle, resumed, and then wrapped past its last beat. Here the held address, the resumed step and the return to the start value all have to agree with one stored start value. The stimulus loads a non-zero start value in each order. It advances part way, holds `adv_n` high for several cycles, then advances through more than one full burst, and compares every beat against start+k or start^k. Load priority over a simultaneous advance, and reset over a simultaneous strobe, are driven on the same edge to test the decode order.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      BCMD_HOLD = 2'd0,
      BCMD_LOAD = 2'd1,
      BCMD_STEP = 2'd2
   } burst_cmd_e;

   // a strobe wins over advance; advance high means suspend
   function automatic burst_cmd_e burst_decode(input logic proc_n,
                                               input logic ctl_n,
                                               input logic adv_n);
      if (!proc_n || !ctl_n) return BCMD_LOAD;
      if (!adv_n)            return BCMD_STEP;
      return BCMD_HOLD;
   endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic                 step,
   output logic [BEAT_BITS-1:0] beat_q,
   output logic [BEAT_BITS-1:0] beat_inc
);
   localparam logic [BEAT_BITS-1:0] ONE = BEAT_BITS'(1);

   assign beat_inc = beat_q + ONE;

   always_ff @(posedge clk) begin
      if (rst)       beat_q <= '0;
      else if (load) beat_q <= '0;
      else if (step) beat_q <= beat_inc;
   end

   // R6: a step moves the index by exactly one (wrap included)
   p_beat_step_r6: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> (beat_q == $past(beat_q) + ONE));

   // R3: load forces beat zero even if step is also requested
   p_load_zero_r3: assert property (@(posedge clk) disable iff (rst)
      load |=> (beat_q == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int BEAT_BITS = 2
) (
   input  logic [BEAT_BITS-1:0] base,
   input  logic [BEAT_BITS-1:0] beat,
   input  logic                 interleaved,
   output logic [BEAT_BITS-1:0] addr
);
   logic [BEAT_BITS-1:0] lin_addr;
   logic [BEAT_BITS-1:0] ilv_addr;

   assign lin_addr = base + beat;

   for (genvar b = 0; b < BEAT_BITS; b++) begin : g_ilv_bit
      assign ilv_addr[b] = base[b] ^ beat[b];
   end

   assign addr = interleaved ? ilv_addr : lin_addr;

endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
   import burst_seq_pkg::*;
#(
   parameter int BEAT_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [BEAT_BITS-1:0] start_addr,
   input  logic                 strb_proc_n,
   input  logic                 strb_ctl_n,
   input  logic                 adv_n,
   input  logic                 order_sel,
   output logic [BEAT_BITS-1:0] addr_lsb,
   output logic [BEAT_BITS-1:0] beat_idx
);
   localparam int BEATS = 1 << BEAT_BITS;

   if (BEAT_BITS < 1 || BEAT_BITS > 8) begin : g_bad_width
      $error("burst_seq_gen: BEAT_BITS must be 1..8");
   end
   if (BEATS < 2) begin : g_bad_len
      $error("burst_seq_gen: burst must hold at least two beats");
   end

   burst_cmd_e           cmd;
   logic                 do_load;
   logic                 do_step;
   logic [BEAT_BITS-1:0] base_q;
   logic [BEAT_BITS-1:0] addr_q;
   logic [BEAT_BITS-1:0] beat_q;
   logic [BEAT_BITS-1:0] beat_inc;
   logic [BEAT_BITS-1:0] next_addr;

   assign cmd     = burst_decode(strb_proc_n, strb_ctl_n, adv_n);
   assign do_load = (cmd == BCMD_LOAD);
   assign do_step = (cmd == BCMD_STEP);

   burst_beat_ctr #(.BEAT_BITS(BEAT_BITS)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (do_load),
      .step     (do_step),
      .beat_q   (beat_q),
      .beat_inc (beat_inc)
   );

   burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
      .base        (base_q),
      .beat        (beat_inc),
      .interleaved (order_sel),
      .addr        (next_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         addr_q <= '0;
      end else begin
         unique case (cmd)
            BCMD_LOAD: begin
               base_q <= start_addr;
               addr_q <= start_addr;
            end
            BCMD_STEP: addr_q <= next_addr;
            default:   ;
         endcase
      end
   end

   assign addr_lsb = addr_q;
   assign beat_idx = beat_q;

   // R1 / R2: either strobe captures the start value
   p_load_start_r1: assert property (@(posedge clk) disable iff (rst)
      (!strb_proc_n || !strb_ctl_n) |=> (addr_lsb == $past(start_addr) && beat_idx == '0));

   // R7: suspend keeps both outputs
   p_suspend_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (strb_proc_n && strb_ctl_n && adv_n) |=> ($stable(addr_lsb) && $stable(beat_idx)));

   // R4: in linear order the address minus the beat is the stored start
   p_linear_key_r4: assert property (@(posedge clk) disable iff (rst)
      (strb_proc_n && strb_ctl_n && !adv_n && !order_sel)
      |=> (BEAT_BITS'(addr_lsb - beat_idx) == $past(base_q)));

   // R5: in interleaved order the address XOR the beat is the stored start
   p_ilv_key_r5: assert property (@(posedge clk) disable iff (rst)
      (strb_proc_n && strb_ctl_n && !adv_n && order_sel)
      |=> ((addr_lsb ^ beat_idx) == $past(base_q)));

endmodule

// File: tb/burst_seq_gen_bench.sv
module burst_seq_gen_bench;
   localparam int W = 2;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] start_addr = '0;
   logic         strb_proc_n = 1'b1;
   logic         strb_ctl_n  = 1'b1;
   logic         adv_n       = 1'b1;
   logic         order_sel   = 1'b1;
   logic [W-1:0] addr_lsb;
   logic [W-1:0] beat_idx;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   burst_seq_gen #(.BEAT_BITS(W)) u_burst_seq_gen (
      .clk(clk), .rst(rst), .start_addr(start_addr),
      .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
      .adv_n(adv_n), .order_sel(order_sel),
      .addr_lsb(addr_lsb), .beat_idx(beat_idx)
   );

   // one edge, then settle 1 ns past it before sampling or driving
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, int got_a, int exp_a, int got_b, int exp_b);
      n_cmp++;
      if (got_a != exp_a || got_b != exp_b) begin
         n_bad++;
         $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                  req, got_a, got_b, exp_a, exp_b);
      end
   endtask

   function automatic int expect_addr(int s, int k, bit ilv);
      return ilv ? ((s ^ k) & 3) : ((s + k) & 3);
   endfunction

   task automatic load(int s, bit use_ctl);
      start_addr  = W'(s);
      strb_proc_n = use_ctl;
      strb_ctl_n  = !use_ctl;
      adv_n       = 1'b1;
      tick();
      strb_proc_n = 1'b1;
      strb_ctl_n  = 1'b1;
   endtask

   task automatic t_reset();
      rst = 1'b1; strb_proc_n = 1'b0; start_addr = 2'd3;
      tick();
      chk("R9 reset", addr_lsb, 0, beat_idx, 0);
      rst = 1'b0; strb_proc_n = 1'b1;
   endtask

   task automatic t_load_proc();
      load(2, 1'b0);
      chk("R1 proc strobe load", addr_lsb, 2, beat_idx, 0);
   endtask

   task automatic t_load_ctl();
      load(3, 1'b1);
      chk("R2 ctl strobe load", addr_lsb, 3, beat_idx, 0);
      start_addr = 2'd1; strb_proc_n = 1'b0; strb_ctl_n = 1'b0;
      tick();
      strb_proc_n = 1'b1; strb_ctl_n = 1'b1;
      chk("R2 both strobes load", addr_lsb, 1, beat_idx, 0);
   endtask

   task automatic t_sequence(int s, bit ilv, string req);
      order_sel = ilv;
      load(s, 1'b0);
      adv_n = 1'b0;
      for (int k = 1; k < 4; k++) begin
         tick();
         chk(req, addr_lsb, expect_addr(s, k, ilv), beat_idx, k);
      end
      adv_n = 1'b1;
   endtask

   task automatic t_suspend_wrap(int s, bit ilv);
      order_sel = ilv;
      load(s, 1'b0);
      adv_n = 1'b0;
      tick();
      adv_n = 1'b1;
      for (int h = 0; h < 3; h++) begin
         tick();
         chk("R7 suspend hold", addr_lsb, expect_addr(s, 1, ilv), beat_idx, 1);
      end
      adv_n = 1'b0;
      for (int k = 2; k < 10; k++) begin
         tick();
         chk(k >= 4 ? "R8 wrap" : "R6 resume", addr_lsb,
             expect_addr(s, k & 3, ilv), beat_idx, k & 3);
      end
      adv_n = 1'b1;
   endtask

   task automatic t_priority();
      order_sel = 1'b0;
      load(0, 1'b0);
      adv_n = 1'b0;
      tick();
      start_addr = 2'd2; strb_ctl_n = 1'b0;
      tick();
      strb_ctl_n = 1'b1; adv_n = 1'b1;
      chk("R3 load over advance", addr_lsb, 2, beat_idx, 0);
   endtask

   initial begin
      #2;
      t_reset();
      t_load_proc();
      t_load_ctl();
      t_sequence(1, 1'b0, "R4 linear");
      t_sequence(3, 1'b0, "R4 linear");
      t_sequence(1, 1'b1, "R5 interleaved");
      t_sequence(2, 1'b1, "R5 interleaved");
      t_sequence(0, 1'b1, "R10 beat index");
      t_suspend_wrap(2, 1'b0);
      t_suspend_wrap(3, 1'b1);
      t_priority();
      t_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule